// File: doc/BRIEF.md
# Out-of-Order Issue Engine with Reservation Stations

This block accepts instructions one at a time, in program order, from an instruction queue and places each into a free reservation station. Register names are renamed into station tags at that point. A source whose register holds a valid value is copied into the station. A source whose register is still awaited takes the tag of the station that will produce it. A station that holds both operands is sent to its functional-unit lane. Each lane returns a result to its own station. Finished stations then take turns on one shared result bus, and every waiting register and station listens to that bus.

The engine keeps the architectural register values and one status tag per register. A read port shows both, so software-free observation of the renaming state is possible. The functional units are outside the block and only have to return each station's result on its own lane, with any latency.

Top module: `ooo_rs_engine`

## Requirements
- R1: After a synchronous active-high reset, every station is free, every register status tag is 0 and register k holds the value k. No dispatch and no result broadcast is active.
- R2: `iq_take` is high exactly when `iq_valid` is high and at least one station is free. The instruction goes into the lowest-numbered free station. Station index i has tag i+1. When all stations are busy, the instruction waits and is not lost.
- R3: At issue, a source register with status tag 0 supplies its value. A source register with a non-zero status tag supplies that tag, and the station waits for it.
- R4: A station is dispatched at most once, and only once both of its operands are present. When several stations are ready, the lowest-numbered one goes first. Dispatch appears on the registered `disp_*` outputs in the cycle after the decision.
- R5: At most one result is broadcast per cycle. When several stations hold finished results, the lowest-numbered one is broadcast and the others keep their results for later cycles.
- R6: On a broadcast, every register whose status tag equals the broadcast tag takes the value and clears its tag. Every station operand waiting on that tag does the same.
- R7: Issue sets the destination register's status tag to the new station's tag and replaces any older pending writer. A later broadcast from the older writer then leaves that register unchanged.
- R8: When an instruction issues in the same cycle that its source's producer is broadcast, the broadcast value goes straight into the new station.
- R9: A station that broadcasts is free in the next cycle and can accept an instruction then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iq_valid | input | 1 | Queue head holds an instruction |
| iq_op | input | OP_W | Operation code, passed through to the functional unit |
| iq_dst | input | log2(NUM_REGS) | Destination register |
| iq_src1 | input | log2(NUM_REGS) | First source register |
| iq_src2 | input | log2(NUM_REGS) | Second source register |
| iq_take | output | 1 | Queue head is accepted this cycle |
| disp_valid | output | 1 | A station is dispatched |
| disp_tag | output | TAG_W | Tag of the dispatched station |
| disp_op | output | OP_W | Operation of the dispatched station |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |
| res_valid | input | NUM_RS | Per-station result strobe from its functional-unit lane |
| res_data | input | NUM_RS x DATA_W | Per-station result value |
| cdb_valid | output | 1 | Result bus carries a broadcast |
| cdb_tag | output | TAG_W | Tag of the broadcasting station |
| cdb_data | output | DATA_W | Broadcast value |
| rd_addr | input | log2(NUM_REGS) | Register read address |
| rd_val | output | DATA_W | Register value |
| rd_tag | output | TAG_W | Register status tag (0 = valid) |

## Verification
The hardest situation to reach from the ports is an issue that needs a tag in exactly the cycle that tag is on the result bus. The bench holds its functional units with a hold flag and releases a single producer. It watches for `cdb_valid`, and only then raises the dependent instruction, so that the issue and the broadcast share that cycle. Two further cases also need held units. In one, several stations finish together, which creates contention for the bus and lets the bench observe a freed station. In the other, two writers target one register, and the bench can see that the stale broadcast is ignored.

// File: rtl/ooo_rs_pkg.sv
package ooo_rs_pkg;
  function automatic int tag_width(input int stations);
    return $clog2(stations + 1);
  endfunction
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N = 4,
  localparam int IW = ooo_rs_pkg::idx_width(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rs_slot.sv
module rs_slot #(
  parameter int DATA_W = 16,
  parameter int OP_W   = 2,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [OP_W-1:0]   ld_op,
  input  logic [TAG_W-1:0]  ld_qj,
  input  logic [TAG_W-1:0]  ld_qk,
  input  logic [DATA_W-1:0] ld_vj,
  input  logic [DATA_W-1:0] ld_vk,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              go,
  input  logic              fin_valid,
  input  logic [DATA_W-1:0] fin_data,
  input  logic              retire,
  output logic              busy,
  output logic              ready,
  output logic              done,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk,
  output logic [DATA_W-1:0] result
);
  logic [TAG_W-1:0] qj, qk;
  logic             exec;

  assign ready = busy && !exec && (qj == '0) && (qk == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; exec <= 1'b0; done <= 1'b0;
      qj <= '0; qk <= '0; op <= '0;
      vj <= '0; vk <= '0; result <= '0;
    end else if (retire) begin
      busy <= 1'b0; exec <= 1'b0; done <= 1'b0;
    end else if (load) begin
      busy <= 1'b1; exec <= 1'b0; done <= 1'b0;
      op <= ld_op; qj <= ld_qj; qk <= ld_qk; vj <= ld_vj; vk <= ld_vk;
    end else begin
      if (busy && bus_valid && qj != '0 && qj == bus_tag) begin
        vj <= bus_data; qj <= '0;
      end
      if (busy && bus_valid && qk != '0 && qk == bus_tag) begin
        vk <= bus_data; qk <= '0;
      end
      if (go) exec <= 1'b1;
      if (fin_valid && exec && !done) begin
        done <= 1'b1; result <= fin_data;
      end
    end
  end

  // R4: execution starts only with both operands present
  p_exec_operands_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(exec) |-> $past(qj == '0 && qk == '0));
  // R5: only a finished station drives the bus
  p_retire_done_r5: assert property (@(posedge clk) disable iff (rst)
    retire |-> done);
  // R9: broadcasting station is free next cycle
  p_free_next_r9: assert property (@(posedge clk) disable iff (rst)
    retire |=> !busy);
endmodule

// File: rtl/ooo_rs_engine.sv
module ooo_rs_engine #(
  parameter int NUM_RS   = 4,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int OP_W     = 2,
  localparam int RW      = ooo_rs_pkg::idx_width(NUM_REGS),
  localparam int TAG_W   = ooo_rs_pkg::tag_width(NUM_RS),
  localparam int IW      = ooo_rs_pkg::idx_width(NUM_RS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           iq_valid,
  input  logic [OP_W-1:0]                iq_op,
  input  logic [RW-1:0]                  iq_dst,
  input  logic [RW-1:0]                  iq_src1,
  input  logic [RW-1:0]                  iq_src2,
  output logic                           iq_take,
  output logic                           disp_valid,
  output logic [TAG_W-1:0]               disp_tag,
  output logic [OP_W-1:0]                disp_op,
  output logic [DATA_W-1:0]              disp_a,
  output logic [DATA_W-1:0]              disp_b,
  input  logic [NUM_RS-1:0]              res_valid,
  input  logic [NUM_RS-1:0][DATA_W-1:0]  res_data,
  output logic                           cdb_valid,
  output logic [TAG_W-1:0]               cdb_tag,
  output logic [DATA_W-1:0]              cdb_data,
  input  logic [RW-1:0]                  rd_addr,
  output logic [DATA_W-1:0]              rd_val,
  output logic [TAG_W-1:0]               rd_tag
);
  logic [NUM_RS-1:0]              s_busy, s_ready, s_done;
  logic [NUM_RS-1:0][OP_W-1:0]    s_op;
  logic [NUM_RS-1:0][DATA_W-1:0]  s_vj, s_vk, s_res;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_val;
  logic [NUM_REGS-1:0][TAG_W-1:0]  reg_tag;

  logic          free_found, disp_found, bus_found;
  logic [IW-1:0] free_idx, disp_idx, bus_idx;
  logic [TAG_W-1:0]  new_tag, q1, q2;
  logic [DATA_W-1:0] v1, v2;
  logic [NUM_RS-1:0] below_mask;

  lowest_pick #(.N(NUM_RS)) u_free (.req(~s_busy), .found(free_found), .idx(free_idx));
  lowest_pick #(.N(NUM_RS)) u_disp (.req(s_ready), .found(disp_found), .idx(disp_idx));
  lowest_pick #(.N(NUM_RS)) u_bus  (.req(s_done),  .found(bus_found),  .idx(bus_idx));

  assign iq_take   = iq_valid && free_found;
  assign new_tag   = TAG_W'(free_idx) + TAG_W'(1);
  assign cdb_valid = bus_found;
  assign cdb_tag   = TAG_W'(bus_idx) + TAG_W'(1);
  assign cdb_data  = s_res[bus_idx];
  assign rd_val    = reg_val[rd_addr];
  assign rd_tag    = reg_tag[rd_addr];

  // Operand read with same-cycle bus forwarding
  always_comb begin
    q1 = reg_tag[iq_src1];
    v1 = reg_val[iq_src1];
    if (q1 != '0 && cdb_valid && q1 == cdb_tag) begin
      v1 = cdb_data; q1 = '0;
    end
    q2 = reg_tag[iq_src2];
    v2 = reg_val[iq_src2];
    if (q2 != '0 && cdb_valid && q2 == cdb_tag) begin
      v2 = cdb_data; q2 = '0;
    end
  end

  for (genvar i = 0; i < NUM_RS; i++) begin : g_slot
    rs_slot #(.DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W)) u_slot (
      .clk(clk), .rst(rst),
      .load(iq_take && free_idx == IW'(i)),
      .ld_op(iq_op), .ld_qj(q1), .ld_qk(q2), .ld_vj(v1), .ld_vk(v2),
      .bus_valid(cdb_valid), .bus_tag(cdb_tag), .bus_data(cdb_data),
      .go(disp_found && disp_idx == IW'(i)),
      .fin_valid(res_valid[i]), .fin_data(res_data[i]),
      .retire(bus_found && bus_idx == IW'(i)),
      .busy(s_busy[i]), .ready(s_ready[i]), .done(s_done[i]),
      .op(s_op[i]), .vj(s_vj[i]), .vk(s_vk[i]), .result(s_res[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0; disp_tag <= '0; disp_op <= '0;
      disp_a <= '0; disp_b <= '0;
    end else begin
      disp_valid <= disp_found;
      disp_tag   <= TAG_W'(disp_idx) + TAG_W'(1);
      disp_op    <= s_op[disp_idx];
      disp_a     <= s_vj[disp_idx];
      disp_b     <= s_vk[disp_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        reg_val[r] <= DATA_W'(r);
        reg_tag[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (cdb_valid && reg_tag[r] != '0 && reg_tag[r] == cdb_tag) begin
          reg_val[r] <= cdb_data;
          reg_tag[r] <= '0;
        end
        if (iq_take && iq_dst == RW'(r)) reg_tag[r] <= new_tag;
      end
    end
  end

  always_comb below_mask = (NUM_RS'(1) << bus_idx) - NUM_RS'(1);

  // R2: no acceptance while every station is occupied
  p_stall_full_r2: assert property (@(posedge clk) disable iff (rst)
    (iq_valid && (&s_busy)) |-> !iq_take);
  // R5: no lower-numbered finished station is passed over
  p_bus_lowest_r5: assert property (@(posedge clk) disable iff (rst)
    cdb_valid |-> ((s_done & below_mask) == '0));
  // R4: a reported dispatch names a station that is still occupied
  p_disp_busy_r4: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> s_busy[disp_tag - TAG_W'(1)]);
  // R6: status tags never name a station that does not exist
  always_comb begin
    if (!rst) p_tag_range_r6: assert (rd_tag <= TAG_W'(NUM_RS));
  end
endmodule

// File: tb/test_ooo_rs_engine.sv
module test_ooo_rs_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NRS = 4, NREG = 8, DW = 16, OW = 2, TW = 3;

  logic clk = 0, rst = 1;
  logic iq_valid = 0;
  logic [OW-1:0] iq_op = 0;
  logic [2:0] iq_dst = 0, iq_src1 = 0, iq_src2 = 0, rd_addr = 0;
  logic iq_take, disp_valid, cdb_valid;
  logic [TW-1:0] disp_tag, cdb_tag, rd_tag;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_a, disp_b, cdb_data, rd_val;
  logic [NRS-1:0] res_valid = 0;
  logic [NRS-1:0][DW-1:0] res_data = '0;

  int checks = 0, errors = 0;
  bit fu_hold = 0;
  bit pend [NRS];
  int cnt [NRS];
  logic [DW-1:0] fval [NRS];
  int disp_count [NRS+1];
  logic [DW-1:0] gold [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  ooo_rs_engine i_ooo_rs_engine (
    .clk(clk), .rst(rst), .iq_valid(iq_valid), .iq_op(iq_op), .iq_dst(iq_dst),
    .iq_src1(iq_src1), .iq_src2(iq_src2), .iq_take(iq_take),
    .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b), .res_valid(res_valid), .res_data(res_data),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .rd_addr(rd_addr), .rd_val(rd_val), .rd_tag(rd_tag));

  function automatic logic [DW-1:0] alu(input logic [OW-1:0] o, input logic [DW-1:0] a, b);
    case (o)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a ^ b;
      default: return a & b;
    endcase
  endfunction

  // Functional-unit lanes: latency op+1, optional hold
  always @(negedge clk) begin
    res_valid <= '0;
    if (rst) begin
      for (int i = 0; i < NRS; i++) pend[i] = 0;
      for (int i = 0; i <= NRS; i++) disp_count[i] = 0;
    end else begin
      for (int i = 0; i < NRS; i++) begin
        if (pend[i]) begin
          if (cnt[i] == 0 && !fu_hold) begin
            res_valid[i] <= 1'b1; res_data[i] <= fval[i]; pend[i] = 0;
          end else if (cnt[i] > 0) cnt[i]--;
        end
      end
      if (disp_valid) begin
        pend[disp_tag-1] = 1; cnt[disp_tag-1] = int'(disp_op);
        fval[disp_tag-1] = alu(disp_op, disp_a, disp_b);
        disp_count[disp_tag]++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1; iq_valid = 0; fu_hold = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    for (int r = 0; r < NREG; r++) gold[r] = DW'(r);
  endtask

  task automatic issue(input int o, d, s1, s2);
    @(negedge clk);
    iq_op = OW'(o); iq_dst = 3'(d); iq_src1 = 3'(s1); iq_src2 = 3'(s2); iq_valid = 1;
    #1;
    for (int k = 0; k < 200 && !iq_take; k++) begin @(negedge clk); #1; end
    @(posedge clk); #1 iq_valid = 0;
    gold[d] = alu(OW'(o), gold[s1], gold[s2]);
  endtask

  task automatic read_reg(input int r);
    rd_addr = 3'(r); #1;
  endtask

  task automatic wait_bus();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #1;
      if (cdb_valid) break;
    end
  endtask

  localparam logic [10:0] PROG [16] = '{
    {2'd0,3'd1,3'd2,3'd3}, {2'd1,3'd4,3'd1,3'd5}, {2'd2,3'd1,3'd4,3'd1},
    {2'd3,3'd6,3'd7,3'd1}, {2'd0,3'd2,3'd6,3'd6}, {2'd0,3'd1,3'd1,3'd2},
    {2'd1,3'd0,3'd3,3'd1}, {2'd2,3'd5,3'd0,3'd4}, {2'd0,3'd7,3'd5,3'd1},
    {2'd3,3'd3,3'd7,3'd2}, {2'd0,3'd4,3'd4,3'd4}, {2'd1,3'd6,3'd3,3'd0},
    {2'd0,3'd1,3'd6,3'd5}, {2'd2,3'd2,3'd1,3'd7}, {2'd0,3'd5,3'd2,3'd2},
    {2'd1,3'd7,3'd5,3'd4}};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    for (int r = 0; r < NREG; r++) begin
      read_reg(r);
      chk(rd_val == DW'(r) && rd_tag == 0, "R1 reg", int'(rd_val), r);
    end
    chk(!disp_valid && !cdb_valid && !iq_take, "R1 idle", int'(disp_valid), 0);

    // R2/R3/R4/R5/R9: fill stations under hold
    fu_hold = 1;
    issue(0, 1, 2, 3);
    read_reg(1); chk(rd_tag == 1, "R2 lowest free tag", int'(rd_tag), 1);
    issue(0, 4, 1, 2);
    read_reg(4); chk(rd_tag == 2, "R3 pending dst tag", int'(rd_tag), 2);
    issue(2, 5, 6, 7);
    issue(1, 6, 2, 3);
    repeat (10) @(posedge clk);
    chk(disp_count[2] == 0, "R4 no dispatch before operand", disp_count[2], 0);
    chk(disp_count[1] == 1, "R4 single dispatch", disp_count[1], 1);
    @(negedge clk); iq_op = 0; iq_dst = 7; iq_src1 = 1; iq_src2 = 0; iq_valid = 1;
    #1 chk(!iq_take, "R2 stall when full", int'(iq_take), 0);
    @(posedge clk); #1 fu_hold = 0;
    wait_bus();
    chk(cdb_valid && cdb_tag == 1, "R5 lowest first", int'(cdb_tag), 1);
    chk(!iq_take, "R9 still full during broadcast", int'(iq_take), 0);
    @(negedge clk); #1;
    chk(cdb_valid && cdb_tag == 3, "R5 held result next", int'(cdb_tag), 3);
    chk(iq_take, "R9 freed station accepts", int'(iq_take), 1);
    @(posedge clk); #1 iq_valid = 0;
    gold[1] = 5; gold[4] = 7; gold[5] = 1; gold[6] = 16'hFFFF; gold[7] = 5;
    @(negedge clk); #1;
    chk(cdb_valid && cdb_tag == 4, "R5 third result", int'(cdb_tag), 4);
    repeat (20) @(posedge clk);
    for (int r = 0; r < NREG; r++) begin
      read_reg(r);
      chk(rd_val == gold[r] && rd_tag == 0, "R6 capture", int'(rd_val), int'(gold[r]));
    end

    // R7: two writers to one register
    do_reset();
    fu_hold = 1;
    issue(0, 5, 1, 2);
    issue(0, 5, 3, 4);
    read_reg(5); chk(rd_tag == 2, "R7 newest writer tag", int'(rd_tag), 2);
    repeat (6) @(posedge clk);
    #1 fu_hold = 0;
    wait_bus();
    chk(cdb_tag == 1, "R7 old writer broadcast", int'(cdb_tag), 1);
    @(negedge clk); read_reg(5);
    chk(rd_val == 5 && rd_tag == 2, "R7 stale result ignored", int'(rd_val), 5);
    repeat (3) @(posedge clk);
    read_reg(5); chk(rd_val == 7 && rd_tag == 0, "R7 final value", int'(rd_val), 7);

    // R8: issue in the same cycle as the producer's broadcast
    do_reset();
    fu_hold = 1;
    issue(0, 3, 1, 1);
    repeat (5) @(posedge clk);
    #1 fu_hold = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (cdb_valid) break;
    end
    iq_op = 0; iq_dst = 4; iq_src1 = 3; iq_src2 = 2; iq_valid = 1;
    #1 chk(cdb_valid && iq_take, "R8 issue meets broadcast", int'(iq_take), 1);
    @(posedge clk); #1 iq_valid = 0;
    read_reg(4); chk(rd_tag == 2, "R8 consumer tag", int'(rd_tag), 2);
    repeat (10) @(posedge clk);
    read_reg(4); chk(rd_val == 4 && rd_tag == 0, "R8 forwarded operand", int'(rd_val), 4);

    // R3/R4/R6/R7: instruction stream against a sequential model
    do_reset();
    for (int n = 0; n < 16; n++)
      issue(int'(PROG[n][10:9]), int'(PROG[n][8:6]), int'(PROG[n][5:3]), int'(PROG[n][2:0]));
    repeat (60) @(posedge clk);
    for (int r = 0; r < NREG; r++) begin
      read_reg(r);
      chk(rd_val == gold[r] && rd_tag == 0, "R6 stream result", int'(rd_val), int'(gold[r]));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule